// File: doc/BRIEF.md
# Three-Entry Fully Associative Translation Cache with Recency Replacement

This block translates 16-bit byte virtual addresses into 16-bit physical addresses, with 8 KB pages. A lookup takes the top three address bits as the virtual page number and compares them against every stored entry in the same cycle. One cycle after the request, the block reports hit or miss. On a hit it also gives the physical address, which is the stored physical page number placed in front of the unchanged 13-bit page offset.

On a miss, a page-table walker outside this block answers with a fill. The fill carries the page number, the frame number and a dirty flag. The block chooses the slot to replace in this order:

- a slot that already holds the same page;
- otherwise the lowest-numbered empty slot;
- otherwise the slot that was used least recently.

Dirty state lives in the cache. A write hit marks the entry dirty. The page table learns about it only when that dirty entry is evicted: the block then raises a one-cycle write-back notice that carries the page number of the evicted entry.

Top module: `vtlb3`

## Requirements
- R1: After reset all entries are invalid, `resp_valid` and `wb_valid` are 0, and the first lookup misses.
- R2: A request accepted at a clock edge produces exactly one `resp_valid` pulse, in the cycle after that edge.
- R3: A lookup hits when `req_va[15:13]` equals the page number of a valid entry. It then returns `resp_hit`=1 and `resp_pa` = {entry frame number, `req_va[12:0]`}.
- R4: A lookup that matches no valid entry returns `resp_hit`=0 and `resp_pa`=0.
- R5: A write hit sets the dirty bit of the matching entry. A read hit leaves the dirty bit unchanged.
- R6: A fill for a page that is not resident replaces the lowest-indexed invalid entry if one exists. Otherwise it replaces the least recently used valid entry.
- R7: Every hit and every fill makes the touched entry the most recently used one. The other entries keep their relative order.
- R8: If a fill evicts a valid dirty entry, `wb_valid` pulses for one cycle after the fill edge, with `wb_vpn` set to the evicted page number. A clean or empty victim produces no pulse.
- R9: The entry installed by a fill is dirty when `fill_dirty` is 1 or when the most recent missed request was a write.
- R10: A fill whose page number is already resident updates that entry in place. It keeps any earlier dirty state, creates no duplicate, and raises no write-back.
- R11: A request presented in the same cycle as a fill is ignored and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 16 | Virtual byte address |
| req_write | input | 1 | 1 = write access, 0 = read |
| fill_valid | input | 1 | Fill strobe from the page-table walker |
| fill_vpn | input | 3 | Page number to install |
| fill_ppn | input | 3 | Frame number to install |
| fill_dirty | input | 1 | Dirty state supplied with the fill |
| resp_valid | output | 1 | Lookup result is valid |
| resp_hit | output | 1 | Lookup hit |
| resp_pa | output | 16 | Translated physical address (0 on miss) |
| wb_valid | output | 1 | Dirty eviction notice |
| wb_vpn | output | 3 | Page number of the evicted dirty entry |

## Verification
The bench replays a reference stream of eleven mixed reads and writes, which forces cold misses, hits that follow fills, and LRU evictions with both clean and dirty victims. Comparing these against a timestamp-based reference model separates a correct replacement order from an index-based or a stale one. A dedicated read miss filled with the dirty flag set, followed by eviction, separates the fill-dirty path from the write-miss path. A refill of a page that is already resident checks the in-place update, and a request that collides with a fill checks that the request is dropped.

// File: rtl/vtlb_pkg.sv
`timescale 1ns/1ps
package vtlb_pkg;
  localparam int unsigned DEF_VA_W      = 16;
  localparam int unsigned DEF_PAGE_BITS = 13;
  localparam int unsigned DEF_PA_W      = 16;
  localparam int unsigned DEF_ENTRIES   = 3;

  // Index of the lowest set bit of a one-hot (or zero) vector.
  function automatic int unsigned oh_index(input logic [31:0] oh);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (oh[i]) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/vtlb_match.sv
`timescale 1ns/1ps
module vtlb_match #(
  parameter int unsigned ENTRIES = 3,
  parameter int unsigned VPN_W   = 3
) (
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tag_i,
  input  logic [VPN_W-1:0]              key_i,
  output logic [ENTRIES-1:0]            hit_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_o[g] = valid_i[g] && (tag_i[g] == key_i);
  end
endmodule

// File: rtl/vtlb_victim.sv
`timescale 1ns/1ps
module vtlb_victim #(
  parameter int unsigned ENTRIES = 3,
  parameter int unsigned IDX_W   = 2
) (
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [ENTRIES-1:0]            resident_i,
  input  logic [ENTRIES-1:0][IDX_W-1:0] age_i,
  output logic [ENTRIES-1:0]            victim_oh_o,
  output logic [IDX_W-1:0]              victim_idx_o
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] first_free;
  logic [ENTRIES-1:0] oldest;
  logic               any_free;

  always_comb begin
    first_free = '0;
    any_free   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid_i[i] && !any_free) begin
        first_free[i] = 1'b1;
        any_free      = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_old
    assign oldest[g] = (age_i[g] == OLDEST);
  end

  always_comb begin
    if (|resident_i)   victim_oh_o = resident_i;
    else if (any_free) victim_oh_o = first_free;
    else               victim_oh_o = oldest;
    victim_idx_o = IDX_W'(vtlb_pkg::oh_index(32'(victim_oh_o)));
  end
endmodule

// File: rtl/vtlb_age.sv
`timescale 1ns/1ps
module vtlb_age #(
  parameter int unsigned ENTRIES = 3,
  parameter int unsigned IDX_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          touch_i,
  input  logic [IDX_W-1:0]              touch_idx_i,
  output logic [ENTRIES-1:0][IDX_W-1:0] age_o
);
  localparam int unsigned SEEN_W = 1 << IDX_W;

  logic [IDX_W-1:0] ref_age;
  assign ref_age = age_o[touch_idx_i];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) age_o[i] <= IDX_W'(i);
    end else if (touch_i) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx_i)  age_o[i] <= '0;
        else if (age_o[i] < ref_age)   age_o[i] <= age_o[i] + 1'b1;
      end
    end
  end

  logic [SEEN_W-1:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < ENTRIES; i++) seen[age_o[i]] = 1'b1;
  end

  // R7: the ages always form a permutation of 0..ENTRIES-1
  p_age_perm_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(seen) == ENTRIES);

  // R7: the touched entry becomes the youngest
  p_touch_young_r7: assert property (@(posedge clk) disable iff (rst)
    touch_i |=> age_o[$past(touch_idx_i)] == '0);
endmodule

// File: rtl/vtlb3.sv
`timescale 1ns/1ps
module vtlb3 #(
  parameter int unsigned VA_W      = vtlb_pkg::DEF_VA_W,
  parameter int unsigned PAGE_BITS = vtlb_pkg::DEF_PAGE_BITS,
  parameter int unsigned PA_W      = vtlb_pkg::DEF_PA_W,
  parameter int unsigned ENTRIES   = vtlb_pkg::DEF_ENTRIES
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [VA_W-1:0]           req_va,
  input  logic                      req_write,
  input  logic                      fill_valid,
  input  logic [VA_W-PAGE_BITS-1:0] fill_vpn,
  input  logic [PA_W-PAGE_BITS-1:0] fill_ppn,
  input  logic                      fill_dirty,
  output logic                      resp_valid,
  output logic                      resp_hit,
  output logic [PA_W-1:0]           resp_pa,
  output logic                      wb_valid,
  output logic [VA_W-PAGE_BITS-1:0] wb_vpn
);
  localparam int unsigned VPN_W = VA_W - PAGE_BITS;
  localparam int unsigned PPN_W = PA_W - PAGE_BITS;
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]            ent_v, ent_d;
  logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn;
  logic [ENTRIES-1:0][PPN_W-1:0] ent_ppn;
  logic                          pend_write;

  logic                          req_fire;
  logic [VPN_W-1:0]              req_vpn;
  logic [ENTRIES-1:0]            look_vec, fillm_vec, vict_oh;
  logic [IDX_W-1:0]              look_idx, vict_idx, touch_idx;
  logic                          look_any, fill_res, touch;
  logic [ENTRIES-1:0][IDX_W-1:0] ages;

  assign req_fire = req_valid && !fill_valid;
  assign req_vpn  = req_va[VA_W-1:PAGE_BITS];

  vtlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_look (
    .valid_i(ent_v), .tag_i(ent_vpn), .key_i(req_vpn), .hit_o(look_vec));

  vtlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fmatch (
    .valid_i(ent_v), .tag_i(ent_vpn), .key_i(fill_vpn), .hit_o(fillm_vec));

  assign look_any = |look_vec;
  assign fill_res = |fillm_vec;
  assign look_idx = IDX_W'(vtlb_pkg::oh_index(32'(look_vec)));

  vtlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .valid_i(ent_v), .resident_i(fillm_vec), .age_i(ages),
    .victim_oh_o(vict_oh), .victim_idx_o(vict_idx));

  assign touch     = fill_valid || (req_fire && look_any);
  assign touch_idx = fill_valid ? vict_idx : look_idx;

  vtlb_age #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_age (
    .clk(clk), .rst(rst), .touch_i(touch), .touch_idx_i(touch_idx), .age_o(ages));

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v      <= '0;
      ent_d      <= '0;
      pend_write <= 1'b0;
    end else begin
      if (req_fire && !look_any) pend_write <= req_write;
      for (int i = 0; i < ENTRIES; i++) begin
        if (fill_valid && vict_oh[i]) begin
          ent_v[i] <= 1'b1;
          ent_d[i] <= fill_dirty || pend_write || (fillm_vec[i] && ent_d[i]);
        end else if (req_fire && look_vec[i] && req_write) begin
          ent_d[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (fill_valid && vict_oh[i]) begin
        ent_vpn[i] <= fill_vpn;
        ent_ppn[i] <= fill_ppn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_pa    <= '0;
      wb_valid   <= 1'b0;
      wb_vpn     <= '0;
    end else begin
      resp_valid <= req_fire;
      resp_hit   <= req_fire && look_any;
      resp_pa    <= (req_fire && look_any) ?
                    {ent_ppn[look_idx], req_va[PAGE_BITS-1:0]} : '0;
      wb_valid   <= fill_valid && !fill_res && ent_v[vict_idx] && ent_d[vict_idx];
      wb_vpn     <= ent_vpn[vict_idx];
    end
  end

  // R2: a response only follows an accepted request
  p_resp_after_req_r2: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(req_valid && !fill_valid));
  // R3: a hit is only reported with a valid response
  p_hit_in_resp_r3: assert property (@(posedge clk) disable iff (rst)
    resp_hit |-> resp_valid);
  // R4: a miss returns a zero address
  p_miss_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_hit) |-> resp_pa == '0);
  // R8: a write-back notice only follows a fill
  p_wb_after_fill_r8: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(fill_valid));
  // R6: a fill always targets exactly one slot
  p_one_victim_r6: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> $countones(vict_oh) == 1);
  // R10: no page number is ever resident twice
  p_no_dup_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(look_vec));
  // R11: a request colliding with a fill gives no response
  p_drop_on_fill_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && fill_valid) |=> !resp_valid);
endmodule

// File: tb/tb_vtlb3.sv
`timescale 1ns/1ps
module tb_vtlb3;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, fill_valid, fill_dirty;
  logic [15:0] req_va;
  logic [2:0]  fill_vpn, fill_ppn;
  logic        resp_valid, resp_hit, wb_valid;
  logic [15:0] resp_pa;
  logic [2:0]  wb_vpn;

  always #2.5 clk = ~clk;

  vtlb3 dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va), .req_write(req_write),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_dirty(fill_dirty),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_pa(resp_pa),
    .wb_valid(wb_valid), .wb_vpn(wb_vpn));

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // scoreboard queues
  bit          q_hit[$];
  logic [15:0] q_pa[$];
  string       q_tag[$];

  // reference model: timestamp-based recency
  bit       m_v[3], m_d[3];
  int       m_vpn[3], m_ppn[3], m_ts[3];
  int       now = 0;
  bit       m_pw = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && resp_valid) begin
      if (q_hit.size() == 0) begin
        chk(1'b0, "R2", "unexpected response", 32'd1, 32'd0);
      end else begin
        automatic bit          eh = q_hit.pop_front();
        automatic logic [15:0] ep = q_pa.pop_front();
        automatic string       t  = q_tag.pop_front();
        chk(resp_hit == eh, t, "hit", 32'(resp_hit), 32'(eh));
        chk(resp_pa == ep, t, "pa", 32'(resp_pa), 32'(ep));
      end
    end
  end

  // driver: one lookup, pushes expected result; returns model hit
  task automatic lookup(input logic [15:0] va, input bit wr, output bit hit);
    automatic int vpn = int'(va[15:13]);
    automatic int k = -1;
    for (int i = 0; i < 3; i++) if (m_v[i] && m_vpn[i] == vpn) k = i;
    hit = (k >= 0);
    if (hit) begin
      q_hit.push_back(1'b1);
      q_pa.push_back({3'(m_ppn[k]), va[12:0]});
      q_tag.push_back("R3/R5/R7");
      if (wr) m_d[k] = 1'b1;
      now++; m_ts[k] = now;
    end else begin
      q_hit.push_back(1'b0);
      q_pa.push_back(16'h0);
      q_tag.push_back("R2/R4");
      m_pw = wr;
    end
    req_valid = 1'b1; req_va = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic fill(input int vpn, input int ppn, input bit fd, input string tag);
    automatic int  k = -1;
    automatic bit  ewb;
    automatic int  evpn = 0;
    automatic bit  res;
    for (int i = 0; i < 3; i++) if (m_v[i] && m_vpn[i] == vpn) k = i;
    res = (k >= 0);
    if (!res) for (int i = 2; i >= 0; i--) if (!m_v[i]) k = i;
    if (k < 0) begin
      k = 0;
      for (int i = 1; i < 3; i++) if (m_ts[i] < m_ts[k]) k = i;
    end
    ewb  = !res && m_v[k] && m_d[k];
    evpn = m_vpn[k];
    m_d[k]   = fd || m_pw || (res && m_d[k]);
    m_v[k]   = 1'b1; m_vpn[k] = vpn; m_ppn[k] = ppn;
    now++; m_ts[k] = now;
    fill_valid = 1'b1; fill_vpn = 3'(vpn); fill_ppn = 3'(ppn); fill_dirty = fd;
    @(negedge clk);
    fill_valid = 1'b0; fill_dirty = 1'b0;
    chk(wb_valid == ewb, tag, "wb_valid", 32'(wb_valid), 32'(ewb));
    if (ewb) chk(wb_vpn == 3'(evpn), tag, "wb_vpn", 32'(wb_vpn), 32'(evpn));
  endtask

  task automatic access(input logic [15:0] va, input bit wr);
    bit h;
    lookup(va, wr, h);
    if (!h) begin
      fill(int'(va[15:13]), (int'(va[15:13]) + 2) % 8, 1'b0, "R6/R8/R9");
      lookup(va, wr, h);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit h;
    rst = 1'b1; req_valid = 1'b0; req_va = '0; req_write = 1'b0;
    fill_valid = 1'b0; fill_vpn = '0; fill_ppn = '0; fill_dirty = 1'b0;
    for (int i = 0; i < 3; i++) begin m_v[i] = 0; m_d[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_ts[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(resp_valid == 1'b0, "R1", "resp_valid after reset", 32'(resp_valid), 32'd0);
    chk(wb_valid == 1'b0, "R1", "wb_valid after reset", 32'(wb_valid), 32'd0);

    // reference stream
    access(16'hA1F4, 0); access(16'hFEA6, 0); access(16'hE208, 1);
    access(16'h2020, 0); access(16'hB03E, 1); access(16'hD021, 1);
    access(16'h689A, 0); access(16'h345C, 1); access(16'hCFDC, 1);
    access(16'h7ED2, 1); access(16'h8038, 0);

    // R9: read miss filled with fill_dirty set, later evicted -> write-back
    lookup(16'h0123, 0, h);
    if (!h) fill(0, 6, 1'b1, "R9");
    access(16'h4444, 0); access(16'h5555, 0); access(16'h2222, 0);
    access(16'h6666, 0); access(16'hA000, 0);

    // R10: refill of a resident page updates in place, no write-back
    lookup(16'hA000, 1, h);
    fill(5, 1, 1'b0, "R10");
    lookup(16'hA00F, 0, h);
    fill(4, 7, 1'b0, "R10"); fill(1, 4, 1'b0, "R10"); fill(2, 5, 1'b0, "R10");

    // R11: request colliding with a fill is dropped
    req_valid = 1'b1; req_va = 16'h2000; req_write = 1'b1;
    fill(6, 0, 1'b0, "R11");
    req_valid = 1'b0;
    @(negedge clk);
    chk(resp_valid == 1'b0, "R11", "no response after collision", 32'(resp_valid), 32'd0);
    lookup(16'h2000, 0, h);

    repeat (3) @(negedge clk);
    chk(q_hit.size() == 0, "R2", "responses outstanding", 32'(q_hit.size()), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule